// File: doc/BRIEF.md
# Lockable Register-Controlled Watchdog Timer

A watchdog timer steered through a single 32-bit control and status register on a plain register bus: a write strobe with write data, and read data that always shows the current register contents. Software programs a timeout in seconds, turns the timer on and then keeps writing a reload bit before the countdown runs out. A prescaler divides the system clock down to a one-second tick, and the countdown decrements once per tick. When the countdown reaches zero, the block raises a reset request for a fixed number of cycles. It also records whether the expiry happened in surveillance mode or in plain mode.

Firmware can set a lock bit once. After that, the enable bit, the timeout field and the lock bit itself can no longer be changed until power-on reset. Reloads still work, and the timeout can still be read. The block has two reset domains. The reset request it drives returns the timer-side state (enable, timeout field, countdown, prescaler) to its defaults, while the lock bit and the two expiry-cause flags are cleared only by the power-on reset. Boot code can therefore see, after a watchdog-caused reset, why the system restarted.

Top module: `wdog_lockreg`

## Requirements
- R1: Register bits 9:0 hold the timeout field f, meaning f+1 seconds. With a tick every TICK_CYCLES clocks, `rst_req` first reads high exactly 1+(f+1)*TICK_CYCLES clock edges after the edge that accepted the write setting enable (the count is taken in the cycle after that edge), for every f from 0 to 1023.
- R2: Bit 14 is the enable bit. While unlocked, writing it 0 stops the countdown, and no reset request follows however long the block then waits.
- R3: Writing 1 to bit 31 on an enabled timer restarts the countdown from the current timeout field, and `rst_req` rises (f+1)*TICK_CYCLES edges after the reload edge. This works whether or not the lock is set.
- R4: A timeout written while the timer is running does not change the running countdown. It takes effect at the next reload or start.
- R5: Bit 12 is the lock bit, and it can be set only once. While it is 1, writes cannot change bit 12, bit 14 or bits 9:0. Only power-on reset clears it.
- R6: While locked, `reg_rdata` still shows the current timeout field, enable and lock. The register is read without delay.
- R7: On expiry, `rst_req` is high for exactly RST_PULSE cycles. Bit 25 is set if `surv_mode` is high at expiry, and bit 24 otherwise. The reset request clears the enable bit and restores the timeout field to TOV_RESET.
- R8: Bits 24 and 25 survive the reset request and are cleared by writing 1 to them. They and the lock bit are 0 after power-on reset. After power-on reset the register reads TOV_RESET in bits 9:0 and 0 everywhere else.
- R9: Bit 31 always reads 0. Reserved bits (all except 9:0, 12, 14, 24, 25, 31) ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears every register |
| reg_we | input | 1 | Register write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| surv_mode | input | 1 | Selects which cause flag an expiry sets |
| rst_req | output | 1 | Reset request pulse, also resets the timer-side state |

## Verification
The hardest state to reach from the ports is a locked timer that has already bitten. To get there, the lock has to be set together with the enable, the countdown has to be driven all the way to expiry, and the timer-side reset has to be allowed to pass. The bench then shows that the lock and the cause flag survived, that the enable stays frozen at 0, and that only a write-one-to-clear or a power-on reset clears the flags. A small prescaler makes every timeout from 0 to 15 seconds, and the largest one, cheap enough to sweep, so the cycle of each expiry can be predicted by arithmetic.

// File: rtl/wdog_lockreg_pkg.sv
package wdog_lockreg_pkg;
  localparam int REG_W      = 32;
  localparam int TOV_W      = 10;
  localparam int LOCK_BIT   = 12;
  localparam int EN_BIT     = 14;
  localparam int CAUSE_LSB  = 24;  // bit 24 plain cause, bit 25 surveillance cause
  localparam int N_CAUSE    = 2;
  localparam int RELOAD_BIT = 31;

  typedef struct packed {
    logic             en;
    logic             lock;
    logic [TOV_W-1:0] tov;
  } wd_ctl_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (clr || !run)    div_q <= '0;
    else if (div_q == LAST)  div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  assign tick = run && !clr && (div_q == LAST);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int TOV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             en,
  input  logic             reload,
  input  logic [TOV_W-1:0] tov,
  input  logic             tick,
  output logic             armed,
  output logic             load,
  output logic             expire
);
  localparam int SW = TOV_W + 1;
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0] secs_q;
  logic          armed_q;

  assign load   = en && (!armed_q || reload);
  assign expire = armed_q && !load && tick && (secs_q == ONE);
  assign armed  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      secs_q  <= '0;
    end else if (warm_rst || !en) begin
      armed_q <= 1'b0;
      secs_q  <= '0;
    end else if (load) begin
      armed_q <= 1'b1;
      secs_q  <= {1'b0, tov} + ONE;
    end else if (tick && secs_q != '0) begin
      secs_q  <= secs_q - ONE;
    end
  end
endmodule

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
  import wdog_lockreg_pkg::*;
#(
  parameter logic [TOV_W-1:0] TOV_RESET = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             expire,
  input  logic             surv_mode,
  output wd_ctl_t          ctl,
  output logic             reload,
  output logic [REG_W-1:0] reg_rdata
);
  logic             en_q;
  logic [TOV_W-1:0] tov_q;
  logic             lock_q;
  logic [N_CAUSE-1:0] cause_q;
  logic             unused_rsvd;

  assign unused_rsvd = ^{reg_wdata[30:26], reg_wdata[23:15], reg_wdata[13],
                         reg_wdata[11:TOV_W]};

  // timer-side domain: power-on or watchdog reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      tov_q <= TOV_RESET;
    end else if (warm_rst) begin
      en_q  <= 1'b0;
      tov_q <= TOV_RESET;
    end else if (reg_we && !lock_q) begin
      en_q  <= reg_wdata[EN_BIT];
      tov_q <= reg_wdata[TOV_W-1:0];
    end
  end

  // sticky domain: power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            lock_q <= 1'b0;
    else if (reg_we && reg_wdata[LOCK_BIT]) lock_q <= 1'b1;
  end

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    logic hit;
    logic w1c;
    assign hit = expire && (surv_mode == (i == 1));
    assign w1c = reg_we && reg_wdata[CAUSE_LSB + i];
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   cause_q[i] <= 1'b0;
      else if (hit) cause_q[i] <= 1'b1;
      else if (w1c) cause_q[i] <= 1'b0;
    end
  end

  assign reload   = reg_we && reg_wdata[RELOAD_BIT];
  assign ctl.en   = en_q;
  assign ctl.lock = lock_q;
  assign ctl.tov  = tov_q;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[TOV_W-1:0] = tov_q;
    reg_rdata[LOCK_BIT]  = lock_q;
    reg_rdata[EN_BIT]    = en_q;
    reg_rdata[CAUSE_LSB +: N_CAUSE] = cause_q;
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire)         left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/wdog_lockreg.sv
module wdog_lockreg
  import wdog_lockreg_pkg::*;
#(
  parameter int                TICK_CYCLES = 100_000_000,
  parameter int                RST_PULSE   = 16,
  parameter logic [TOV_W-1:0]  TOV_RESET   = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             surv_mode,
  output logic             rst_req
);
  wd_ctl_t ctl;
  logic    reload, tick, armed, load, expire;

  wdog_ctl_regs #(.TOV_RESET(TOV_RESET)) u_regs (
    .clk(clk), .por_n(por_n), .warm_rst(rst_req),
    .reg_we(reg_we), .reg_wdata(reg_wdata),
    .expire(expire), .surv_mode(surv_mode),
    .ctl(ctl), .reload(reload), .reg_rdata(reg_rdata)
  );

  wdog_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(por_n), .run(armed), .clr(load), .tick(tick)
  );

  wdog_countdown #(.TOV_W(TOV_W)) u_cnt (
    .clk(clk), .rst_n(por_n), .warm_rst(rst_req),
    .en(ctl.en), .reload(reload), .tov(ctl.tov), .tick(tick),
    .armed(armed), .load(load), .expire(expire)
  );

  wdog_rst_pulse #(.PULSE_CYCLES(RST_PULSE)) u_pulse (
    .clk(clk), .rst_n(por_n), .fire(expire), .active(rst_req)
  );
endmodule

// File: rtl/wdog_lockreg_chk.sv
module wdog_lockreg_chk #(
  parameter int RST_PULSE = 16
) (
  input logic        clk,
  input logic        por_n,
  input logic        reg_we,
  input logic        clr_plain,
  input logic [31:0] reg_rdata,
  input logic        rst_req
);
  localparam logic [31:0] LIVE_MASK = 32'h0300_53FF;
  int unsigned hi_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_len <= 0;
    else if (rst_req) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[12] |=> reg_rdata[12]);

  a_r5_locked_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[12] && !rst_req) |=> ($stable(reg_rdata[14]) && $stable(reg_rdata[9:0])));

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_req) |-> (hi_len == RST_PULSE));

  a_r7_cause_on_expiry: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> (reg_rdata[24] || reg_rdata[25]));

  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[24] && !(reg_we && clr_plain)) |=> reg_rdata[24]);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata & ~LIVE_MASK) == 32'h0);
endmodule

bind wdog_lockreg wdog_lockreg_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .por_n(por_n), .reg_we(reg_we), .clr_plain(reg_wdata[24]),
  .reg_rdata(reg_rdata), .rst_req(rst_req)
);

// File: tb/wdog_lockreg_test.sv
`timescale 1ns/1ps
module wdog_lockreg_test;
  localparam int TICK  = 4;
  localparam int PULSE = 5;
  localparam logic [31:0] EN = 32'h0000_4000, LK = 32'h0000_1000,
                          RL = 32'h8000_0000, C0 = 32'h0100_0000, C1 = 32'h0200_0000;

  logic clk = 0, por_n = 0, reg_we = 0, surv_mode = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rst_req;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_lockreg #(.TICK_CYCLES(TICK), .RST_PULSE(PULSE), .TOV_RESET(10'h3FF)) uut (
    .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .surv_mode(surv_mode), .rst_req(rst_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk); por_n = 0; idle(2); por_n = 1; @(negedge clk);
  endtask

  // edges from the last write until rst_req reads high
  task automatic wait_rst(output int n);
    n = 0;
    while (!rst_req && n < 20000) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    idle(3); por_n = 1; @(negedge clk);
    // R8 reset state
    chk("R8 reset value", reg_rdata, 32'h0000_03FF);
    chk("R7 no request at reset", {31'b0, rst_req}, 32'h0);

    // R1/R7/R8 sweep over timeouts and cause modes
    for (int f = 0; f < 17; f++) begin
      int tv = (f == 16) ? 1023 : f;
      logic [31:0] cause;
      surv_mode = f[0];
      cause = f[0] ? C1 : C0;
      por();
      wr(EN | 32'(tv));
      wait_rst(n);
      chk($sformatf("R1 expiry f=%0d", tv), n, 1 + (tv + 1) * TICK);
      pulse_len(n);
      chk("R7 pulse length", n, PULSE);
      chk("R7 cause and timer reset", reg_rdata, cause | 32'h3FF);
      wr(cause);
      chk("R8 cause cleared by write one", reg_rdata, 32'h0);
    end
    surv_mode = 0;

    // R2 stop while unlocked
    por();
    wr(EN | 3); idle(5); wr(32'h3);
    seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (rst_req) seen = 1; end
    chk("R2 disabled timer never expires", {31'b0, seen}, 32'h0);

    // R3 reload restarts countdown
    por();
    wr(EN | 3); idle(9); wr(RL | EN | 3);
    wait_rst(n);
    chk("R3 expiry after reload", n, 4 * TICK);
    pulse_len(n);

    // R4 new timeout waits for reload
    por();
    wr(EN | 7); idle(4); wr(EN | 1);
    wait_rst(n);
    chk("R4 running count unchanged", n, 1 + 8 * TICK - 5);
    pulse_len(n);
    wr(EN | 7); idle(2); wr(EN | 1); wr(RL | EN | 1);
    wait_rst(n);
    chk("R4 new timeout used at reload", n, 2 * TICK);
    pulse_len(n);

    // R5/R6 lock
    por();
    wr(LK | EN | 2);
    chk("R5 lock set with enable", reg_rdata, 32'h0000_5002);
    wr(32'h5);
    chk("R6 locked fields read back unchanged", reg_rdata, 32'h0000_5002);
    idle(2); wr(RL);
    wait_rst(n);
    chk("R3 reload while locked", n, 3 * TICK);
    pulse_len(n);
    chk("R8 lock and cause survive request", reg_rdata, 32'h0100_13FF);
    wr(EN | 1);
    chk("R5 enable frozen while locked", reg_rdata, 32'h0100_13FF);
    wr(C0);
    chk("R8 cause cleared while locked", reg_rdata, 32'h0000_13FF);
    por();
    chk("R8 power-on clears lock", reg_rdata, 32'h0000_03FF);

    // R9 reserved bits and reload readback
    wr(32'hFFFF_FFFF);
    chk("R9 reserved zero, reload reads 0", reg_rdata, 32'h0000_53FF);
    por();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule